// File: doc/BRIEF.md
# Dual-Input Timer Edge Capture Unit

This block timestamps signal transitions. A 16-bit counter runs freely from zero after reset, adding one on every clock. Two asynchronous capture pins are brought into the clock domain through a two-flop synchroniser each. When a synchronised pin changes level, the counter value is copied into a byte-wide capture register. Each pin has one register for rising transitions and one for falling transitions.

Software reaches a configuration byte and the four capture bytes over a plain byte-wide register bus. It has a write strobe, an address, write data and combinational read data, and no handshake. There are two operating modes. In narrow mode each pin owns its two registers, and a prescale field picks which eight-bit window of the counter is stored. In wide mode only pin 0 captures. Its low counter byte goes into pin 0's registers and its high byte goes into pin 1's registers, both taken at the same instant. Pin 1 transitions are then dropped.

Top module: `tmr_edge_capture`

## Requirements
- R1: After reset, the counter, the configuration byte (address 0x21) and all four capture bytes (0x22 pin 0 rising, 0x23 pin 1 rising, 0x24 pin 0 falling, 0x25 pin 1 falling) read zero.
- R2: In narrow mode, a low-to-high change on a pin loads that pin's rising register and leaves its falling register alone. If the pin changes while the counter holds T, the stored full count is T+2: one clock for each synchroniser stage, then the load.
- R3: In narrow mode, a high-to-low change on a pin loads that pin's falling register with the count from the same timing as R2.
- R4: Configuration byte 0x21 holds bit 0 = wide mode and bits [3:1] = prescale p. In narrow mode every capture stores counter bits [p+7:p], so p=7 stores bits [14:7].
- R5: In wide mode, a rising change on pin 0 stores count bits [7:0] in 0x22 and count bits [15:8] in 0x23, both from the same count, whatever the prescale.
- R6: In wide mode, a falling change on pin 0 stores the low count byte in 0x24 and the high byte in 0x25, both from the same count.
- R7: In wide mode, changes on pin 1 are ignored. Registers 0x23 and 0x25 keep their values.
- R8: A bus write to 0x21..0x25 loads that register, and reading it returns the written byte.
- R9: When a capture and a bus write target the same register on the same clock edge, the capture value is kept and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 2 | Asynchronous capture pins, bit 0 is pin 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr, zero for unmapped addresses |

## Verification
A synchronised pin transition and a software write can land on the same capture register at the same clock edge. The bench provokes this by changing pin 0 and then placing a write to that pin's falling register exactly two clocks later, so that the write strobe is sampled on the edge where the capture loads. The bench judges the outcome by reading the register back. The value must equal the count the bench predicted for the transition, and the write data is chosen to differ from that count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned DAT_W = 8;
  localparam int unsigned TMR_W = 2 * DAT_W;
  localparam int unsigned PS_W  = 3;
  localparam int unsigned ADR_W = 8;
  localparam int unsigned N_PIN = 2;
  localparam int unsigned SYNC_N = 2;

  localparam logic [ADR_W-1:0] A_CFG = 8'h21;
  localparam logic [ADR_W-1:0] A_R0R = 8'h22;
  localparam logic [ADR_W-1:0] A_R1R = 8'h23;
  localparam logic [ADR_W-1:0] A_R0F = 8'h24;
  localparam logic [ADR_W-1:0] A_R1F = 8'h25;

  // packed so that wide sits in bit 0 and prescale in bits [3:1]
  typedef struct packed {
    logic [PS_W-1:0] pscl;
    logic            wide;
  } cfg_t;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/cap_free_timer.sv
module cap_free_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import cap_pkg::*;
#(
  parameter int unsigned DW = DAT_W,
  parameter int unsigned TW = TMR_W,
  parameter int unsigned AW = ADR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [1:0]           rise,
  input  logic [1:0]           fall,
  input  logic [TW-1:0]        tmr,
  output cfg_t                 cfg,
  output logic [1:0][DW-1:0]   cap_lo,
  output logic [1:0][DW-1:0]   cap_hi
);
  cfg_t          cfg_q;
  logic [TW-1:0] shifted;
  logic [DW-1:0] slice;

  assign shifted = tmr >> cfg_q.pscl;
  assign slice   = shifted[DW-1:0];
  assign cfg     = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg_q <= '0;
    else if (wr && addr == A_CFG)  cfg_q <= cfg_t'(wdata[PS_W:0]);
  end

  // g = 0: rising pair (0x22/0x23); g = 1: falling pair (0x24/0x25)
  for (genvar g = 0; g < 2; g++) begin : g_pol
    localparam logic [AW-1:0] LO_A = (g == 0) ? A_R0R : A_R0F;
    localparam logic [AW-1:0] HI_A = (g == 0) ? A_R1R : A_R1F;
    logic          ev0, ev1, hi_ev;
    logic [DW-1:0] lo_q, hi_q;

    assign ev0   = (g == 0) ? rise[0] : fall[0];
    assign ev1   = (g == 0) ? rise[1] : fall[1];
    assign hi_ev = cfg_q.wide ? ev0 : ev1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lo_q <= '0;
      else if (ev0)                lo_q <= cfg_q.wide ? tmr[DW-1:0] : slice;
      else if (wr && addr == LO_A) lo_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hi_q <= '0;
      else if (hi_ev)              hi_q <= cfg_q.wide ? tmr[2*DW-1:DW] : slice;
      else if (wr && addr == HI_A) hi_q <= wdata;
    end

    assign cap_lo[g] = lo_q;
    assign cap_hi[g] = hi_q;
  end
endmodule

// File: rtl/tmr_edge_capture.sv
module tmr_edge_capture
  import cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PIN-1:0]  cap_in,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [DAT_W-1:0]  bus_wdata,
  output logic [DAT_W-1:0]  bus_rdata
);
  logic [TMR_W-1:0]         tmr_q;
  logic [N_PIN-1:0]         rise_v, fall_v;
  cfg_t                     cfg_q;
  logic [1:0][DAT_W-1:0]    cap_lo, cap_hi;

  cap_free_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt(tmr_q)
  );

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    cap_sync_edge #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[i]),
      .rise(rise_v[i]), .fall(fall_v[i])
    );
  end

  cap_regfile #(.DW(DAT_W), .TW(TMR_W), .AW(ADR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rise(rise_v), .fall(fall_v), .tmr(tmr_q),
    .cfg(cfg_q), .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = DAT_W'(cfg_q);
      A_R0R:   bus_rdata = cap_lo[0];
      A_R1R:   bus_rdata = cap_hi[0];
      A_R0F:   bus_rdata = cap_lo[1];
      A_R1F:   bus_rdata = cap_hi[1];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADR_W-1:0]     bus_addr,
  input logic [DAT_W-1:0]     bus_wdata,
  input logic [TMR_W-1:0]     tmr,
  input logic [1:0]           rise,
  input logic [1:0]           fall,
  input cfg_t                 cfg,
  input logic [1:0][DAT_W-1:0] cap_lo,
  input logic [1:0][DAT_W-1:0] cap_hi
);
  logic [TMR_W-1:0] sh_c;
  logic [DAT_W-1:0] win_c;
  assign sh_c  = tmr >> cfg.pscl;
  assign win_c = sh_c[DAT_W-1:0];

  AST_NARROW_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && !cfg.wide) |=> cap_lo[0] == $past(win_c)); // R2
  AST_NARROW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[1] && !cfg.wide) |=> cap_hi[1] == $past(win_c)); // R3
  AST_WIDE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && cfg.wide) |=> {cap_hi[0], cap_lo[0]} == $past(tmr)); // R5
  AST_WIDE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[0] && cfg.wide) |=> {cap_hi[1], cap_lo[1]} == $past(tmr)); // R6
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.wide && !rise[0] && !(bus_wr && bus_addr == A_R1R)) |=> $stable(cap_hi[0])); // R7
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_R0F && !fall[0]) |=> cap_lo[1] == $past(bus_wdata)); // R8
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_R0F && fall[0] && !cfg.wide) |=> cap_lo[1] == $past(win_c)); // R9
endmodule

bind tmr_edge_capture cap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tmr(tmr_q), .rise(rise_v), .fall(fall_v),
  .cfg(cfg_q), .cap_lo(cap_lo), .cap_hi(cap_hi)
);

// File: tb/test_tmr_edge_capture.sv
module test_tmr_edge_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap_in = 2'b00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] tb_cnt = 16'h0;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (rst_n) tb_cnt <= tb_cnt + 16'd1;

  tmr_edge_capture i_tmr_edge_capture (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  // change a pin, return full count the capture should hold
  task automatic move_pin(input int ch, input logic v, output logic [15:0] exp);
    @(negedge clk); cap_in[ch] = v; exp = tb_cnt + 16'd2;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 8'h21; a <= 8'h25; a++) begin
      rd_reg(8'(a), d); chk("R1 reset value", d, 8'h00);
    end
  endtask

  task automatic t_narrow_rise;
    logic [15:0] e; logic [7:0] d;
    wr_reg(8'h21, 8'h00);
    move_pin(0, 1'b1, e);
    rd_reg(8'h22, d); chk("R2 pin0 rising", d, e[7:0]);
    rd_reg(8'h24, d); chk("R2 pin0 falling untouched", d, 8'h00);
    move_pin(1, 1'b1, e);
    rd_reg(8'h23, d); chk("R2 pin1 rising", d, e[7:0]);
  endtask

  task automatic t_narrow_fall;
    logic [15:0] e; logic [7:0] d;
    move_pin(0, 1'b0, e);
    rd_reg(8'h24, d); chk("R3 pin0 falling", d, e[7:0]);
    move_pin(1, 1'b0, e);
    rd_reg(8'h25, d); chk("R3 pin1 falling", d, e[7:0]);
  endtask

  task automatic t_prescale;
    logic [15:0] e, s; logic [7:0] d;
    repeat (300) @(negedge clk);
    wr_reg(8'h21, 8'h08);              // p = 4
    move_pin(0, 1'b1, e); s = e >> 4;
    rd_reg(8'h22, d); chk("R4 prescale 4", d, s[7:0]);
    wr_reg(8'h21, 8'h0E);              // p = 7
    rd_reg(8'h21, d); chk("R4 config readback", d, 8'h0E);
    move_pin(1, 1'b1, e); s = e >> 7;
    rd_reg(8'h23, d); chk("R4 prescale 7", d, s[7:0]);
  endtask

  task automatic t_wide_fall;
    logic [15:0] e; logic [7:0] d;
    repeat (600) @(negedge clk);
    wr_reg(8'h21, 8'h07);              // wide, p = 3 (unused)
    move_pin(0, 1'b0, e);
    rd_reg(8'h24, d); chk("R6 wide falling low", d, e[7:0]);
    rd_reg(8'h25, d); chk("R6 wide falling high", d, e[15:8]);
  endtask

  task automatic t_wide_rise;
    logic [15:0] e; logic [7:0] d;
    move_pin(0, 1'b1, e);
    rd_reg(8'h22, d); chk("R5 wide rising low", d, e[7:0]);
    rd_reg(8'h23, d); chk("R5 wide rising high", d, e[15:8]);
  endtask

  task automatic t_wide_ignore;
    logic [15:0] e; logic [7:0] h_r, h_f, d;
    rd_reg(8'h23, h_r); rd_reg(8'h25, h_f);
    move_pin(1, 1'b0, e);
    move_pin(1, 1'b1, e);
    rd_reg(8'h23, d); chk("R7 pin1 ignored rising reg", d, h_r);
    rd_reg(8'h25, d); chk("R7 pin1 ignored falling reg", d, h_f);
  endtask

  task automatic t_write;
    logic [7:0] d;
    wr_reg(8'h21, 8'h00);
    wr_reg(8'h24, 8'hA5);
    rd_reg(8'h24, d); chk("R8 write 0x24", d, 8'hA5);
    wr_reg(8'h23, 8'h3C);
    rd_reg(8'h23, d); chk("R8 write 0x23", d, 8'h3C);
  endtask

  task automatic t_conflict;
    logic [15:0] e; logic [7:0] d, wd;
    @(negedge clk); cap_in[0] = 1'b0; e = tb_cnt + 16'd2;
    wd = ~e[7:0];
    repeat (2) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = wd;
    @(negedge clk); bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(8'h24, d); chk("R9 capture beats write", d, e[7:0]);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_narrow_rise();
    t_narrow_fall();
    t_prescale();
    t_wide_fall();
    t_wide_rise();
    t_wide_ignore();
    t_write();
    t_conflict();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule